// File: doc/BRIEF.md
# Root Port Interrupt Decode Unit

This block gathers the miscellaneous event pulses of a PCIe root-port bridge into one interrupt line. Each event arrives as a single-cycle pulse on a 32-bit event bus. A pulse on a defined bit sets a sticky bit in the decode register. A mask register selects which pending bits may raise the interrupt. The interrupt output is a level: it stays high while any pending bit is also enabled.

Software reaches the block through a 32-bit register port. Writes take effect on the clock edge. Reads are combinational from the address. Pending bits clear on write-one, so writing back a value just read acknowledges exactly those events. The block also keeps a small queue of incoming error messages. Software sees the oldest entry through a dedicated register and pops it by writing any value to that register.

The queue is controlled by a three-state machine:
- `Q_EMPTY`: no entries are held. A push moves to `Q_PARTIAL`.
- `Q_PARTIAL`: between one and DEPTH-1 entries are held. It moves to `Q_EMPTY` when the count reaches zero and to `Q_FULL` when the count reaches DEPTH.
- `Q_FULL`: DEPTH entries are held. A pop moves to `Q_PARTIAL`.

Top module: `irqdec_unit`

## Requirements
- R1: After reset, the decode register, the mask register and the queue register (0x154) all read zero, and `misc_irq` is low.
- R2: A one-cycle pulse on a defined event bit sets that decode bit from the next cycle on, and the bit stays set until software clears it. The defined positions are:
  - link down: bit 0
  - hot reset: bit 3
  - config completion status: bits 7:5
  - config timeout: bit 8
  - correctable error: bit 9
  - non-fatal error: bit 10
  - fatal error: bit 11
  - INTx: bit 16
  - MSI: bit 17
  - AXI slave and master errors: bits 27:20
- R3: A write to offset 0x138 clears exactly the decode bits written as one. Bits written as zero are left unchanged.
- R4: When an event pulse and a write-one-to-clear hit the same bit in the same cycle, the event wins and the bit stays set.
- R5: The mask register sits at offset 0x13C and reads back what was written. A 1 in a mask bit enables that source. `misc_irq` is high exactly when (decode AND mask) is non-zero, and it stays low while the mask is zero.
- R6: Undefined bits (outside mask 0x0FF30FE9) always read zero. Events on undefined bits are ignored, and mask writes to undefined bits are ignored.
- R7: Reading offset 0x154 returns the oldest queued error message. Bit 18 is set when an entry is present, bits 15:0 hold its requester ID, and all other bits are zero. An empty queue reads 0.
- R8: Any write to offset 0x154 removes the oldest entry. Such a write has no effect when the queue is empty.
- R9: The queue holds DEPTH (default 4) entries in arrival order. A message that arrives while the queue is full is dropped.
- R10: Any other offset reads zero, and writes to any other offset change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_pulse | input | 32 | Single-cycle event pulses, one per decode bit |
| errmsg_push | input | 1 | An error message arrives this cycle |
| errmsg_reqid | input | 16 | Requester ID of the arriving error message |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| misc_irq | output | 1 | Level interrupt: any pending bit is also enabled |

## Verification
The hardest situation to reach from the ports is an event pulse landing in the same cycle as a clear write to the same bit. The bench raises the event bus and the write strobe together on one falling edge, so both arrive at the same rising edge. A full queue that receives one more message is also hard to reach. The bench pushes DEPTH+1 messages back to back with no pop in between, then drains the queue to show that only the first DEPTH survive, in order.

// File: rtl/irqdec_pkg.sv
package irqdec_pkg;
    localparam int DATA_W  = 32;
    localparam int ADDR_W  = 12;
    localparam int REQID_W = 16;

    localparam logic [ADDR_W-1:0] OFF_DECODE = 12'h138;
    localparam logic [ADDR_W-1:0] OFF_ENABLE = 12'h13C;
    localparam logic [ADDR_W-1:0] OFF_ERRQ   = 12'h154;

    // Positions that carry a real event source
    localparam logic [DATA_W-1:0] LIVE_BITS = 32'h0FF3_0FE9;

    localparam int ERRQ_VALID_POS = 18;

    typedef enum logic [1:0] {
        Q_EMPTY,
        Q_PARTIAL,
        Q_FULL
    } errq_state_e;
endpackage

// File: rtl/irqdec_status.sv
module irqdec_status #(
    parameter int                WIDTH = 32,
    parameter logic [WIDTH-1:0]  LIVE  = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] evt,
    input  logic             clr_en,
    input  logic [WIDTH-1:0] clr_bits,
    input  logic             en_we,
    input  logic [WIDTH-1:0] en_wdata,
    output logic [WIDTH-1:0] pending,
    output logic [WIDTH-1:0] enable
);
    logic [WIDTH-1:0] clr_vec;
    logic [WIDTH-1:0] set_vec;

    always_comb begin
        clr_vec = clr_en ? clr_bits : '0;
        set_vec = evt & LIVE;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending <= '0;
            enable  <= '0;
        end else begin
            pending <= (pending & ~clr_vec) | set_vec;
            if (en_we) begin
                enable <= en_wdata & LIVE;
            end
        end
    end

    // R2 R4
    evt_sets_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(evt & LIVE)) |=> ((pending & $past(evt & LIVE)) == $past(evt & LIVE)));

    // R3
    pending_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_en && ((evt & LIVE) == '0)) |=> $stable(pending));
endmodule

// File: rtl/irqdec_errq.sv
module irqdec_errq
    import irqdec_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int IDW   = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           push,
    input  logic [IDW-1:0] push_id,
    input  logic           pop,
    output logic           head_valid,
    output logic [IDW-1:0] head_id
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(DEPTH);

    logic [IDW-1:0]   slot [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [CNT_W-1:0] count, count_d;
    errq_state_e      state_q, state_d;
    logic             push_ok, pop_ok;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        push_ok = push && (state_q != Q_FULL);
        pop_ok  = pop  && (state_q != Q_EMPTY);
        count_d = count + CNT_W'(push_ok) - CNT_W'(pop_ok);
        state_d = state_q;
        unique case (state_q)
            Q_EMPTY:   if (push_ok) state_d = (count_d == CNT_MAX) ? Q_FULL : Q_PARTIAL;
            Q_PARTIAL: begin
                if (count_d == '0)          state_d = Q_EMPTY;
                else if (count_d == CNT_MAX) state_d = Q_FULL;
            end
            Q_FULL:    if (pop_ok) state_d = (count_d == '0) ? Q_EMPTY : Q_PARTIAL;
            default:   state_d = Q_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= Q_EMPTY;
            count   <= '0;
            wr_ptr  <= '0;
            rd_ptr  <= '0;
        end else begin
            state_q <= state_d;
            count   <= count_d;
            if (push_ok) wr_ptr <= bump(wr_ptr);
            if (pop_ok)  rd_ptr <= bump(rd_ptr);
        end
    end

    always_ff @(posedge clk) begin
        if (push_ok) slot[wr_ptr] <= push_id;
    end

    always_comb begin
        head_valid = (state_q != Q_EMPTY);
        head_id    = head_valid ? slot[rd_ptr] : '0;
    end

    // R9
    full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == Q_FULL && !pop) |=> (state_q == Q_FULL));

    // R8
    empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == Q_EMPTY && !push) |=> (state_q == Q_EMPTY));
endmodule

// File: rtl/irqdec_unit.sv
module irqdec_unit
    import irqdec_pkg::*;
#(
    parameter int ERRQ_DEPTH = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [DATA_W-1:0]  evt_pulse,
    input  logic               errmsg_push,
    input  logic [REQID_W-1:0] errmsg_reqid,
    input  logic               reg_wr_en,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic [DATA_W-1:0]  reg_wdata,
    output logic [DATA_W-1:0]  reg_rdata,
    output logic               misc_irq
);
    logic [DATA_W-1:0]  pending, enable;
    logic               q_valid;
    logic [REQID_W-1:0] q_id;
    logic               wr_dec, wr_en_reg, wr_q;

    always_comb begin
        wr_dec    = reg_wr_en && (reg_addr == OFF_DECODE);
        wr_en_reg = reg_wr_en && (reg_addr == OFF_ENABLE);
        wr_q      = reg_wr_en && (reg_addr == OFF_ERRQ);
    end

    irqdec_status #(.WIDTH(DATA_W), .LIVE(LIVE_BITS)) u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt      (evt_pulse),
        .clr_en   (wr_dec),
        .clr_bits (reg_wdata),
        .en_we    (wr_en_reg),
        .en_wdata (reg_wdata),
        .pending  (pending),
        .enable   (enable)
    );

    irqdec_errq #(.DEPTH(ERRQ_DEPTH), .IDW(REQID_W)) u_errq (
        .clk        (clk),
        .rst_n      (rst_n),
        .push       (errmsg_push),
        .push_id    (errmsg_reqid),
        .pop        (wr_q),
        .head_valid (q_valid),
        .head_id    (q_id)
    );

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            OFF_DECODE: reg_rdata = pending;
            OFF_ENABLE: reg_rdata = enable;
            OFF_ERRQ: begin
                reg_rdata[ERRQ_VALID_POS] = q_valid;
                reg_rdata[REQID_W-1:0]    = q_id;
            end
            default:    reg_rdata = '0;
        endcase
        misc_irq = |(pending & enable);
    end

    // R5
    masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (enable == '0) |-> !misc_irq);

    // R5
    irq_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (misc_irq && !wr_dec && !wr_en_reg) |=> misc_irq);
endmodule

// File: tb/tb_irqdec_unit.sv
module tb_irqdec_unit;
    logic        clk = 0;
    logic        rst_n = 0;
    logic [31:0] evt_pulse = '0;
    logic        errmsg_push = 0;
    logic [15:0] errmsg_reqid = '0;
    logic        reg_wr_en = 0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        misc_irq;

    int checks = 0;
    int errors = 0;

    localparam logic [11:0] A_DEC = 12'h138, A_EN = 12'h13C, A_Q = 12'h154;

    irqdec_unit dut (.*);

    always #4 clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr_en = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr_en = 0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic pulse(input logic [31:0] e);
        @(negedge clk);
        evt_pulse = e;
        @(negedge clk);
        evt_pulse = '0;
    endtask

    task automatic push_msg(input logic [15:0] id);
        @(negedge clk);
        errmsg_push = 1; errmsg_reqid = id;
        @(negedge clk);
        errmsg_push = 0;
    endtask

    task automatic t_reset;
        logic [31:0] v;
        rd(A_DEC, v); check("R1 decode", v, 0);
        rd(A_EN, v);  check("R1 mask", v, 0);
        rd(A_Q, v);   check("R1 queue", v, 0);
        check("R1 irq", {31'b0, misc_irq}, 0);
    endtask

    task automatic t_set;
        logic [31:0] v;
        pulse(32'h0000_0009);
        rd(A_DEC, v); check("R2 link/hot", v, 32'h0000_0009);
        pulse(32'h0FF0_0000);
        rd(A_DEC, v); check("R2 axi bits", v, 32'h0FF0_0009);
        check("R5 irq masked", {31'b0, misc_irq}, 0);
    endtask

    task automatic t_undef;
        logic [31:0] v;
        pulse(32'hF00C_F016);
        rd(A_DEC, v); check("R6 undefined events", v, 32'h0FF0_0009);
        wr(A_EN, 32'hFFFF_FFFF);
        rd(A_EN, v); check("R6 mask readback", v, 32'h0FF3_0FE9);
        check("R5 irq enabled", {31'b0, misc_irq}, 1);
    endtask

    task automatic t_w1c;
        logic [31:0] v;
        wr(A_DEC, 32'h0000_0009);
        rd(A_DEC, v); check("R3 partial clear", v, 32'h0FF0_0000);
        wr(A_DEC, v);
        rd(A_DEC, v); check("R3 write-back clear", v, 0);
        check("R5 irq drops", {31'b0, misc_irq}, 0);
    endtask

    task automatic t_prio;
        logic [31:0] v;
        pulse(32'h0000_0200);
        @(negedge clk);
        evt_pulse = 32'h0000_0200;
        reg_wr_en = 1; reg_addr = A_DEC; reg_wdata = 32'h0000_0600;
        @(negedge clk);
        evt_pulse = '0; reg_wr_en = 0;
        rd(A_DEC, v); check("R4 set beats clear", v, 32'h0000_0200);
    endtask

    task automatic t_mask;
        logic [31:0] v;
        wr(A_EN, 32'h0000_0400);
        check("R5 bit9 masked", {31'b0, misc_irq}, 0);
        pulse(32'h0000_0400);
        check("R5 bit10 enabled", {31'b0, misc_irq}, 1);
        wr(A_EN, 32'h0);
        check("R5 mask zero", {31'b0, misc_irq}, 0);
        wr(A_DEC, 32'hFFFF_FFFF);
        rd(A_DEC, v); check("R3 clear all", v, 0);
    endtask

    task automatic t_fifo;
        logic [31:0] v;
        push_msg(16'h1111); push_msg(16'h2222); push_msg(16'h3333);
        push_msg(16'h4444); push_msg(16'h5555);
        rd(A_Q, v); check("R7 head", v, 32'h0004_1111);
        rd(A_Q, v); check("R7 read keeps head", v, 32'h0004_1111);
        wr(A_Q, 32'h0);
        rd(A_Q, v); check("R9 order 2", v, 32'h0004_2222);
        wr(A_Q, 32'hDEAD_BEEF);
        rd(A_Q, v); check("R9 order 3", v, 32'h0004_3333);
        wr(A_Q, 32'h1);
        rd(A_Q, v); check("R9 order 4", v, 32'h0004_4444);
        wr(A_Q, 32'h1);
        rd(A_Q, v); check("R9 overflow dropped", v, 0);
        wr(A_Q, 32'h1);
        rd(A_Q, v); check("R8 pop on empty", v, 0);
        push_msg(16'hABCD);
        rd(A_Q, v); check("R8 after empty pop", v, 32'h0004_ABCD);
        wr(A_Q, 32'h0);
    endtask

    task automatic t_other;
        logic [31:0] v;
        pulse(32'h0000_0001);
        wr(12'h140, 32'hFFFF_FFFF);
        rd(12'h140, v); check("R10 other read", v, 0);
        rd(A_DEC, v);   check("R10 other write", v, 32'h0000_0001);
        rd(A_EN, v);    check("R10 mask untouched", v, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset();
        t_set();
        t_undef();
        t_w1c();
        t_prio();
        t_mask();
        t_fifo();
        t_other();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #400000;
        checks++; errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule